// File: doc/BRIEF.md
# Dual-Clock First-Word-Fall-Through FIFO

This block carries data words from a write clock domain to an unrelated read clock domain. Words enter on the write clock whenever the writer enables a write and the queue is not full. The oldest stored word always sits on the read data output with its valid flag high, so the reader sees it without asking. Raising read enable consumes that word, and the next one follows.

Read and write pointers are one bit wider than the storage address. They cross between the domains as Gray codes through a parameterised chain of synchronizer flops. Each side computes its occupancy against the synchronized copy of the other side's pointer. A side may therefore report fewer free slots or fewer stored words than are really there, but never more. Each side has threshold flags and a one-cycle status pulse for every rejected or accepted request.

Top module: `afifo_fwft`

## Requirements
- R1: While at least one word is stored, `rd_valid_o` is high and `rd_data_o` shows the oldest stored word with no read requested. A read consumes that word, and words leave in the order they were written.
- R2: While `rst_ni` is low and after it is released, the FIFO is empty: `empty_o`=1, `prog_empty_o`=1, `rd_valid_o`=0, `rd_data_o`=0. All other flags and pulses are 0.
- R3: `full_o` is high when DEPTH words are stored. A write while full is dropped and leaves the contents intact. `overflow_o` is then high for exactly one write-clock cycle after the rejected edge.
- R4: A read while empty changes nothing. `underflow_o` is then high for exactly one read-clock cycle after that edge.
- R5: `wr_ack_o` is high for one write-clock cycle after each accepted write, and low after rejected or idle cycles.
- R6: On the write side, once the pointers have settled, `prog_full_o` is high exactly when the stored count is at least PROG_FULL_TH.
- R7: On the read side, once the pointers have settled, `prog_empty_o` is high exactly when the stored count is at most PROG_EMPTY_TH.
- R8: `almost_full_o` is high exactly when DEPTH-1 words are stored, so one more write is possible. `almost_empty_o` is high exactly when one word is stored.
- R9: Pointers cross the clock domains as Gray codes, so each published pointer changes by at most one bit per clock. Flags are never optimistic: a writer that writes only while `full_o` is low, and a reader that reads only while `rd_valid_o` is high, never cause overflow or underflow.
- R10: `rd_data_o` is 0 whenever `empty_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk_i | input | 1 | Write clock |
| rd_clk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DW | Write data |
| full_o | output | 1 | DEPTH words stored |
| almost_full_o | output | 1 | Exactly one free slot |
| prog_full_o | output | 1 | Count at or above PROG_FULL_TH |
| wr_ack_o | output | 1 | Previous write accepted |
| overflow_o | output | 1 | Previous write rejected |
| rd_en_i | input | 1 | Read (pop) request |
| rd_data_o | output | DW | Oldest stored word, 0 when empty |
| rd_valid_o | output | 1 | rd_data_o holds a word |
| empty_o | output | 1 | No word stored |
| almost_empty_o | output | 1 | Exactly one word stored |
| prog_empty_o | output | 1 | Count at or below PROG_EMPTY_TH |
| underflow_o | output | 1 | Previous read rejected |

## Verification
Some properties are checked on every cycle by assertions. Published Gray pointers change by at most one bit per clock. A rejected write or read leaves its pointer in place and raises its pulse. An accepted request advances the pointer by one. Neither side ever sees an occupancy above DEPTH. Only the bench scenarios can show the rest. These are the word order across the two unrelated clocks, the exact threshold crossings during a full fill and drain, and that an overflow attempt does not corrupt stored data. They also show that flag-obeying traffic never produces an overflow or underflow pulse.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  typedef struct packed {
    logic full;
    logic almost_full;
    logic prog_full;
    logic ack;
    logic overflow;
  } wr_stat_t;

  typedef struct packed {
    logic empty;
    logic almost_empty;
    logic prog_empty;
    logic underflow;
  } rd_stat_t;
endpackage

// File: rtl/afifo_ptr_sync.sv
module afifo_ptr_sync #(
  parameter int PW     = 5,
  parameter int STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] gray_i,
  output logic [PW-1:0] bin_o
);
  logic [PW-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= gray_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  // gray -> binary on the last stage
  always_comb begin
    bin_o[PW-1] = stg[STAGES-1][PW-1];
    for (int i = PW-2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ stg[STAGES-1][i];
  end
endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl
  import afifo_pkg::*;
#(
  parameter int AW      = 4,
  parameter int PF_TH   = 12,
  localparam int PW     = AW + 1,
  localparam int DEPTH  = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [PW-1:0] rptr_bin_i,
  output logic [PW-1:0] wptr_gray_o,
  output logic [AW-1:0] waddr_o,
  output logic          we_o,
  output wr_stat_t      stat_o
);
  logic [PW-1:0] wptr_bin, wptr_nxt, wcount;
  logic          full, accept, ack_q, ovf_q;

  always_comb begin
    wcount   = wptr_bin - rptr_bin_i;
    full     = (wcount == PW'(DEPTH));
    accept   = wr_en_i & ~full;
    wptr_nxt = wptr_bin + PW'(accept);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_bin    <= '0;
      wptr_gray_o <= '0;
      ack_q       <= 1'b0;
      ovf_q       <= 1'b0;
    end else begin
      wptr_bin    <= wptr_nxt;
      wptr_gray_o <= wptr_nxt ^ (wptr_nxt >> 1);
      ack_q       <= accept;
      ovf_q       <= wr_en_i & full;
    end
  end

  assign waddr_o = wptr_bin[AW-1:0];
  assign we_o    = accept;

  always_comb begin
    stat_o.full        = full;
    stat_o.almost_full = (wcount == PW'(DEPTH - 1));
    stat_o.prog_full   = (wcount >= PW'(PF_TH));
    stat_o.ack         = ack_q;
    stat_o.overflow    = ovf_q;
  end

  // R3
  wr_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && stat_o.full) |=> (stat_o.overflow && $stable(wptr_bin)));
  // R5
  wr_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !stat_o.full) |=> (stat_o.ack && wptr_bin == $past(wptr_bin) + 1'b1));
  // R9
  wr_gray_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wptr_gray_o ^ $past(wptr_gray_o)));
  // R3
  wr_occupancy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcount <= PW'(DEPTH));
endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl
  import afifo_pkg::*;
#(
  parameter int AW      = 4,
  parameter int PE_TH   = 3,
  localparam int PW     = AW + 1,
  localparam int DEPTH  = 1 << AW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_en_i,
  input  logic [PW-1:0] wptr_bin_i,
  output logic [PW-1:0] rptr_gray_o,
  output logic [AW-1:0] raddr_o,
  output rd_stat_t      stat_o
);
  logic [PW-1:0] rptr_bin, rptr_nxt, rcount;
  logic          empty, take, unf_q;

  always_comb begin
    rcount   = wptr_bin_i - rptr_bin;
    empty    = (rcount == '0);
    take     = rd_en_i & ~empty;
    rptr_nxt = rptr_bin + PW'(take);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_bin    <= '0;
      rptr_gray_o <= '0;
      unf_q       <= 1'b0;
    end else begin
      rptr_bin    <= rptr_nxt;
      rptr_gray_o <= rptr_nxt ^ (rptr_nxt >> 1);
      unf_q       <= rd_en_i & empty;
    end
  end

  assign raddr_o = rptr_bin[AW-1:0];

  always_comb begin
    stat_o.empty        = empty;
    stat_o.almost_empty = (rcount == PW'(1));
    stat_o.prog_empty   = (rcount <= PW'(PE_TH));
    stat_o.underflow    = unf_q;
  end

  // R4
  rd_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && stat_o.empty) |=> (stat_o.underflow && $stable(rptr_bin)));
  // R1
  rd_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !stat_o.empty) |=> (rptr_bin == $past(rptr_bin) + 1'b1));
  // R9
  rd_gray_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rptr_gray_o ^ $past(rptr_gray_o)));
  // R9
  rd_occupancy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcount <= PW'(DEPTH));
endmodule

// File: rtl/afifo_fwft.sv
module afifo_fwft
  import afifo_pkg::*;
#(
  parameter int DW            = 8,
  parameter int AW            = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int PROG_FULL_TH  = 12,
  parameter int PROG_EMPTY_TH = 3
) (
  input  logic          wr_clk_i,
  input  logic          rd_clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          full_o,
  output logic          almost_full_o,
  output logic          prog_full_o,
  output logic          wr_ack_o,
  output logic          overflow_o,
  input  logic          rd_en_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          empty_o,
  output logic          almost_empty_o,
  output logic          prog_empty_o,
  output logic          underflow_o
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_gray, rptr_gray, wptr_bin_rs, rptr_bin_ws;
  logic [AW-1:0] waddr, raddr;
  logic          we;
  wr_stat_t      ws;
  rd_stat_t      rs;

  afifo_wr_ctl #(.AW(AW), .PF_TH(PROG_FULL_TH)) u_wr (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .rptr_bin_i(rptr_bin_ws), .wptr_gray_o(wptr_gray),
    .waddr_o(waddr), .we_o(we), .stat_o(ws));

  afifo_rd_ctl #(.AW(AW), .PE_TH(PROG_EMPTY_TH)) u_rd (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en_i),
    .wptr_bin_i(wptr_bin_rs), .rptr_gray_o(rptr_gray),
    .raddr_o(raddr), .stat_o(rs));

  afifo_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rd_clk_i), .rst_ni(rst_ni), .gray_i(wptr_gray), .bin_o(wptr_bin_rs));

  afifo_ptr_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wr_clk_i), .rst_ni(rst_ni), .gray_i(rptr_gray), .bin_o(rptr_bin_ws));

  always_ff @(posedge wr_clk_i) begin
    if (we) mem[waddr] <= wr_data_i;
  end

  // fall-through: head word read combinationally, word lands before its pointer crosses
  assign rd_data_o      = rs.empty ? '0 : mem[raddr];
  assign rd_valid_o     = ~rs.empty;
  assign empty_o        = rs.empty;
  assign almost_empty_o = rs.almost_empty;
  assign prog_empty_o   = rs.prog_empty;
  assign underflow_o    = rs.underflow;
  assign full_o         = ws.full;
  assign almost_full_o  = ws.almost_full;
  assign prog_full_o    = ws.prog_full;
  assign wr_ack_o       = ws.ack;
  assign overflow_o     = ws.overflow;

  // R2
  rd_reset_chk: assert property (@(posedge rd_clk_i) !rst_ni |=> empty_o);
  // R2
  wr_reset_chk: assert property (@(posedge wr_clk_i) !rst_ni |=> !full_o);
endmodule

// File: tb/afifo_fwft_bench.sv
`timescale 1ns/1ps
module afifo_fwft_bench;
  localparam int DW = 8, AW = 4, DEPTH = 16, PF = 12, PE = 3, NSTREAM = 300;

  logic wclk = 0, rclk = 0, rst_ni = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic full, afull, pfull, ack, ovf, valid, empty, aempty, pempty, unf;
  logic [DW-1:0] rd_data;
  int errors = 0, checks = 0;

  always #2.5 wclk = ~wclk;
  always #3.7 rclk = ~rclk;

  afifo_fwft #(.DW(DW), .AW(AW), .SYNC_STAGES(2), .PROG_FULL_TH(PF), .PROG_EMPTY_TH(PE)) u_afifo_fwft (
    .wr_clk_i(wclk), .rd_clk_i(rclk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .full_o(full), .almost_full_o(afull), .prog_full_o(pfull),
    .wr_ack_o(ack), .overflow_o(ovf),
    .rd_en_i(rd_en), .rd_data_o(rd_data), .rd_valid_o(valid),
    .empty_o(empty), .almost_empty_o(aempty), .prog_empty_o(pempty),
    .underflow_o(unf));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic rd_flags(input string tag, input int n);
    eq({tag, " R1 valid"}, int'(valid), int'(n > 0));
    eq({tag, " R10 empty"}, int'(empty), int'(n == 0));
    eq({tag, " R8 almost_empty"}, int'(aempty), int'(n == 1));
    eq({tag, " R7 prog_empty"}, int'(pempty), int'(n <= PE));
  endtask

  task automatic wr_flags(input string tag, input int n);
    eq({tag, " R3 full"}, int'(full), int'(n == DEPTH));
    eq({tag, " R8 almost_full"}, int'(afull), int'(n == DEPTH - 1));
    eq({tag, " R6 prog_full"}, int'(pfull), int'(n >= PF));
  endtask

  initial begin
    #500us;
    errors++; checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit bad_pulse;
    int got, sent;
    repeat (3) @(negedge wclk);
    // R2 during reset
    eq("R2 rd_data in reset", int'(rd_data), 0);
    eq("R2 empty in reset", int'(empty), 1);
    rst_ni = 1;
    settle();
    rd_flags("R2 post-reset", 0);
    wr_flags("R2 post-reset", 0);
    eq("R2 ack", int'(ack), 0);
    eq("R2 overflow", int'(ovf), 0);
    eq("R2 underflow", int'(unf), 0);
    eq("R10 data when empty", int'(rd_data), 0);

    // R4 read while empty
    @(negedge rclk); rd_en = 1;
    @(negedge rclk); rd_en = 0;
    eq("R4 underflow pulse", int'(unf), 1);
    eq("R4 still empty", int'(empty), 1);
    @(negedge rclk);
    eq("R4 underflow one cycle", int'(unf), 0);
    settle();
    wr_flags("R4 no pointer move", 0);

    // fill sweep
    for (int k = 1; k <= DEPTH; k++) begin
      @(negedge wclk); wr_en = 1; wr_data = 8'(8'h30 + k);
      @(negedge wclk); wr_en = 0;
      eq("R5 ack on accepted write", int'(ack), 1);
      wr_flags("fill", k);
      settle();
      eq("R5 ack drops when idle", int'(ack), 0);
      rd_flags("fill", k);
      eq("R1 head before read", int'(rd_data), 8'h31);
    end

    // R3 write while full
    @(negedge wclk); wr_en = 1; wr_data = 8'hEE;
    @(negedge wclk); wr_en = 0;
    eq("R3 overflow pulse", int'(ovf), 1);
    eq("R5 no ack on rejected", int'(ack), 0);
    eq("R3 still full", int'(full), 1);
    @(negedge wclk);
    eq("R3 overflow one cycle", int'(ovf), 0);
    settle();

    // drain sweep
    for (int k = DEPTH; k >= 1; k--) begin
      @(negedge rclk);
      eq("R1 head order", int'(rd_data), int'(8'(8'h30 + DEPTH - k + 1)));
      rd_en = 1;
      @(negedge rclk); rd_en = 0;
      eq("R4 no underflow on valid read", int'(unf), 0);
      rd_flags("drain", k - 1);
      settle();
      wr_flags("drain", k - 1);
    end
    eq("R10 data after drain", int'(rd_data), 0);

    // R9 streaming across unrelated clocks, flag-obeying traffic
    bad_pulse = 0; got = 0; sent = 0;
    fork
      begin
        int c = 0;
        while (sent < NSTREAM) begin
          @(negedge wclk);
          c++;
          if (ovf) bad_pulse = 1;
          if (!full && (c % 5 != 3)) begin
            wr_en = 1; wr_data = 8'(sent) ^ 8'h5A; sent++;
          end else wr_en = 0;
        end
        @(negedge wclk); wr_en = 0;
        if (ovf) bad_pulse = 1;
      end
      begin
        int c = 0;
        while (got < NSTREAM) begin
          @(negedge rclk);
          c++;
          if (unf) bad_pulse = 1;
          rd_en = 0;
          if (valid && (c % 4 != 1)) begin
            if (rd_data != (8'(got) ^ 8'h5A)) begin
              eq("R1 stream order", int'(rd_data), int'(8'(got) ^ 8'h5A));
            end
            rd_en = 1; got++;
          end
        end
        @(negedge rclk); rd_en = 0;
        if (unf) bad_pulse = 1;
      end
    join
    eq("R1 stream count", got, NSTREAM);
    eq("R9 no overflow/underflow pulses", int'(bad_pulse), 0);
    settle();
    rd_flags("R9 after stream", 0);
    wr_flags("R9 after stream", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule